// File: doc/BRIEF.md
# Strobe-Counted Wake Pin Debouncer

This block filters two wake-up pins before they are allowed to raise a wake-up. It does not measure the debounce time in cycles of its own clock. Instead it counts pulses of a periodic reference strobe that some other block generates. The strobe arrives as a single-cycle pulse on the block's clock. A pin must hold its active level across a programmed number of these strobes before its wake-up is recognised. This lets a fast domain apply a long, low-power filter without needing a wide cycle counter.

A 3-bit period code sets the required strobe count. Each pin has its own enable. Each pin also has its own sticky status flag, which records that this pin produced a wake-up. A single clear command resets both pins. The combined wake output is high whenever either flag is set. Each pin is resynchronised through two flip-flops before it reaches its counter. Its counter returns to zero as soon as the synchronised pin leaves the active level. The active level is a parameter and defaults to high.

Top module: `wkpin_debounce_top`

## Requirements
- R1: While reset is low at a clock edge, both status flags and the wake output are 0 after that edge.
- R2: Period code 0 turns filtering off: no status flag becomes set, however long a pin stays active and however many strobes arrive.
- R3: With period code n (1 to 7), a pin's flag sets at the clock edge of the (n+1)th strobe counted while its synchronised pin is continuously active; after only n strobes it stays 0.
- R4: When a synchronised pin drops to the inactive level, its count restarts from zero, so strobes from separate active runs do not add up.
- R5: A count advances only in a cycle with the reference strobe high; an active pin with no strobes never sets its flag.
- R6: A pin whose enable bit is 0 never sets its flag. Enables are bit 0 for pin 0 and bit 1 for pin 1, and one pin's enable has no effect on the other pin.
- R7: A status flag is sticky. It stays set after the pin goes inactive, and only reset or the clear command lowers it.
- R8: The clear command zeroes both flags and both counts at the same edge. It wins over a set in that same cycle, and after it a full new count is needed.
- R9: The wake output is high in exactly the cycles in which at least one status flag (bit 0 for pin 0, bit 1 for pin 1) is set.
- R10: Each pin passes through two synchroniser flops, so a strobe is counted only from the third clock edge after the pin becomes active at the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_period | input | 3 | Period code: 0 turns filtering off, n requires n+1 strobes |
| cfg_pin_en | input | 2 | Per-pin enable, bit 0 is pin 0 |
| clear_cmd | input | 1 | Zeroes both status flags and both counts |
| ref_tick | input | 1 | One-cycle reference strobe |
| wake_pin_in | input | 2 | Asynchronous wake pins, bit 0 is pin 0 |
| pin_status | output | 2 | Sticky per-pin wake flags |
| wake_out | output | 1 | OR of the status flags |

## Verification
A counter that keeps a stale value shows up as a status flag that sets too early. This happens on the first strobe after an interrupted run or after a clear, when the count is still one or more strobes short of the target. It becomes visible at the port in the cycle right after that strobe. A synchroniser with the wrong depth moves every flag edge by one cycle. A reference model that is compared on every clock therefore flags it at the first wake-up. A flag that is not held sticky, or a clear that does not take priority, shows up as a status bit that differs from the model one cycle after the pin falls or after the clear.

// File: rtl/wkd_pkg.sv
// Package: shared sizes and helpers for the strobe-counted wake pin debouncer.
// Assumes the period code width stays small (a handful of bits).
package wkd_pkg;

    // Default number of wake pins handled by one instance.
    localparam int unsigned WKD_PINS     = 2;
    // Default width of the period code.
    localparam int unsigned WKD_PERIOD_W = 3;

    // Counter width able to hold the largest target, 2**pw.
    function automatic int unsigned wkd_cnt_width(input int unsigned pw);
        return $clog2((1 << pw) + 1);
    endfunction

endpackage

// File: rtl/wkd_sync.sv
// Module: wkd_sync
// Two-flop resynchroniser for a vector of asynchronous pins.
// Assumes each bit is independent; no bus coherency is implied.
module wkd_sync #(
    parameter int unsigned WIDTH     = 2,
    parameter logic        RESET_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic stage_a;
        logic stage_b;

        // Shift the raw pin through two flops to settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_a <= RESET_VAL;
                stage_b <= RESET_VAL;
            end else begin
                stage_a <= async_in[b];
                stage_b <= stage_a;
            end
        end

        assign sync_out[b] = stage_b;
    end

endmodule

// File: rtl/wkd_period_decode.sv
// Module: wkd_period_decode
// Turns the period code into a filter-on flag and a strobe-count target.
// Assumes code 0 means off and code n means n+1 strobes.
module wkd_period_decode #(
    parameter int unsigned PERIOD_W = 3,
    parameter int unsigned CNT_W    = 4
) (
    input  logic [PERIOD_W-1:0] cfg_period,
    output logic                filt_on,
    output logic [CNT_W-1:0]    target
);

    localparam int unsigned PAD_W = CNT_W - PERIOD_W;

    // Decode the code into an on flag and a zero-extended target.
    always_comb begin
        filt_on = (cfg_period != '0);
        target  = {{PAD_W{1'b0}}, cfg_period} + CNT_W'(1);
    end

endmodule

// File: rtl/wkd_pin_counter.sv
// Module: wkd_pin_counter
// Strobe counter and sticky status for one synchronised wake pin.
// Assumes the pin is already synchronised and the strobe lasts one cycle.
module wkd_pin_counter #(
    parameter int unsigned CNT_W      = 4,
    parameter logic        ACTIVE_LVL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_sync,
    input  logic             pin_en,
    input  logic             filt_on,
    input  logic [CNT_W-1:0] target,
    input  logic             ref_tick,
    input  logic             clear_cmd,
    output logic             flag
);

    logic [CNT_W-1:0] count;
    logic [CNT_W:0]   count_inc;
    logic             live;
    logic             reach;

    // The pin is counted only while active, enabled and filtering is on.
    always_comb begin
        live      = (pin_sync == ACTIVE_LVL) && pin_en && filt_on;
        count_inc = {1'b0, count} + (CNT_W + 1)'(1);
        reach     = live && ref_tick && (count_inc >= {1'b0, target});
    end

    // Count strobes during an active run; restart when the run breaks.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_cmd || !live) begin
            count <= '0;
        end else if (ref_tick && (count < target)) begin
            count <= count_inc[CNT_W-1:0];
        end
    end

    // Latch the wake flag when the target is met; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_cmd) begin
            flag <= 1'b0;
        end else if (reach) begin
            flag <= 1'b1;
        end
    end

endmodule

// File: rtl/wkpin_debounce_top.sv
// Module: wkpin_debounce_top
// Debounces wake pins by counting pulses of an external reference strobe.
// Assumes ref_tick is a one-cycle pulse on clk and the pins are asynchronous.
module wkpin_debounce_top #(
    parameter int unsigned NUM_PINS   = wkd_pkg::WKD_PINS,
    parameter int unsigned PERIOD_W   = wkd_pkg::WKD_PERIOD_W,
    parameter logic        ACTIVE_LVL = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic [NUM_PINS-1:0] cfg_pin_en,
    input  logic                clear_cmd,
    input  logic                ref_tick,
    input  logic [NUM_PINS-1:0] wake_pin_in,
    output logic [NUM_PINS-1:0] pin_status,
    output logic                wake_out
);

    localparam int unsigned CNT_W = wkd_pkg::wkd_cnt_width(PERIOD_W);

    logic [NUM_PINS-1:0] pin_sync;
    logic                filt_on;
    logic [CNT_W-1:0]    target;

    wkd_sync #(
        .WIDTH     (NUM_PINS),
        .RESET_VAL (~ACTIVE_LVL)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wake_pin_in),
        .sync_out (pin_sync)
    );

    wkd_period_decode #(
        .PERIOD_W (PERIOD_W),
        .CNT_W    (CNT_W)
    ) u_decode (
        .cfg_period (cfg_period),
        .filt_on    (filt_on),
        .target     (target)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        wkd_pin_counter #(
            .CNT_W      (CNT_W),
            .ACTIVE_LVL (ACTIVE_LVL)
        ) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_sync  (pin_sync[p]),
            .pin_en    (cfg_pin_en[p]),
            .filt_on   (filt_on),
            .target    (target),
            .ref_tick  (ref_tick),
            .clear_cmd (clear_cmd),
            .flag      (pin_status[p])
        );
    end

    // Combined wake request: any latched pin flag.
    assign wake_out = |pin_status;

endmodule

// File: rtl/wkd_checker.sv
// Module: wkd_checker
// Temporal checks on the debouncer ports, attached by bind.
// Assumes a synchronous active-low reset.
module wkd_checker #(
    parameter int unsigned NUM_PINS = 2,
    parameter int unsigned PERIOD_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [PERIOD_W-1:0] cfg_period,
    input logic [NUM_PINS-1:0] cfg_pin_en,
    input logic                clear_cmd,
    input logic                ref_tick,
    input logic [NUM_PINS-1:0] pin_status
);

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (pin_status == '0));

    p_off_no_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_period == '0 && !clear_cmd) |=> (pin_status == $past(pin_status)));

    p_no_tick_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> ((pin_status & ~$past(pin_status)) == '0));

    p_disabled_no_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pin_status & ~$past(pin_status) & ~$past(cfg_pin_en)) == '0));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_cmd |=> (($past(pin_status) & ~pin_status) == '0));

    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_cmd |=> (pin_status == '0));

endmodule

bind wkpin_debounce_top wkd_checker #(
    .NUM_PINS (NUM_PINS),
    .PERIOD_W (PERIOD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_period (cfg_period),
    .cfg_pin_en (cfg_pin_en),
    .clear_cmd  (clear_cmd),
    .ref_tick   (ref_tick),
    .pin_status (pin_status)
);

// File: tb/wkpin_debounce_top_test.sv
// Bench: behavioural model compared every clock plus directed checks.
module wkpin_debounce_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_period = 3'd0;
    logic [1:0] cfg_pin_en = 2'b00;
    logic       clear_cmd = 1'b0;
    logic       ref_tick = 1'b0;
    logic [1:0] wake_pin_in = 2'b00;
    logic [1:0] pin_status;
    logic       wake_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Behavioural model state
    bit m_s1 [2];
    bit m_s2 [2];
    int m_cnt [2];
    bit m_st [2];

    always #4 clk = ~clk;

    wkpin_debounce_top uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_period  (cfg_period),
        .cfg_pin_en  (cfg_pin_en),
        .clear_cmd   (clear_cmd),
        .ref_tick    (ref_tick),
        .wake_pin_in (wake_pin_in),
        .pin_status  (pin_status),
        .wake_out    (wake_out)
    );

    // Reference model update at each edge.
    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                m_s1[i] = 0; m_s2[i] = 0; m_cnt[i] = 0; m_st[i] = 0;
            end else begin
                bit live;
                int need;
                live = m_s2[i] && cfg_pin_en[i] && (cfg_period != 0);
                need = int'(cfg_period) + 1;
                if (clear_cmd) begin
                    m_cnt[i] = 0; m_st[i] = 0;
                end else if (!live) begin
                    m_cnt[i] = 0;
                end else if (ref_tick) begin
                    if (m_cnt[i] + 1 >= need) m_st[i] = 1;
                    if (m_cnt[i] < need) m_cnt[i] = m_cnt[i] + 1;
                end
                m_s2[i] = m_s1[i];
                m_s1[i] = wake_pin_in[i];
            end
        end
    end

    // Per-cycle comparison against the model (R3 model, R9 wake output).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (pin_status !== {m_st[1], m_st[0]}) begin
                failures++;
                $display("FAIL R3 model status actual=%b expected=%b", pin_status, {m_st[1], m_st[0]});
            end
            checks++;
            if (wake_out !== (m_st[0] | m_st[1])) begin
                failures++;
                $display("FAIL R9 model wake actual=%b expected=%b", wake_out, m_st[0] | m_st[1]);
            end
        end
    end

    task automatic expect_st(input string req, input logic [1:0] exp_st);
        checks++;
        if (pin_status !== exp_st || wake_out !== (|exp_st)) begin
            failures++;
            $display("FAIL %s status=%b wake=%b expected status=%b wake=%b",
                     req, pin_status, wake_out, exp_st, |exp_st);
        end
    endtask

    // One clock with the given strobe value; returns at the next negedge.
    task automatic cyc(input logic t);
        ref_tick = t;
        @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic run(input int n, input logic t);
        for (int k = 0; k < n; k++) cyc(t);
    endtask

    task automatic do_clear();
        clear_cmd = 1'b1;
        cyc(1'b0);
        clear_cmd = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        run(3, 1'b0);
        rst_n = 1'b1;
        expect_st("R1 reset", 2'b00);
        cyc(1'b0);
        expect_st("R1 after reset", 2'b00);

        // R3: code 1 needs two strobes
        cfg_period = 3'd1; cfg_pin_en = 2'b01; wake_pin_in = 2'b01;
        run(2, 1'b0);
        cyc(1'b1);
        expect_st("R3 one of two", 2'b00);
        cyc(1'b1);
        expect_st("R3 two of two", 2'b01);

        // R7: sticky after pin drops
        wake_pin_in = 2'b00;
        run(4, 1'b1);
        expect_st("R7 sticky", 2'b01);

        // R8: clear
        do_clear();
        expect_st("R8 clear", 2'b00);

        // R5: no strobes, no set
        wake_pin_in = 2'b01;
        run(10, 1'b0);
        expect_st("R5 no strobe", 2'b00);

        // R8: clear also zeroes the count (code 3 = 4 strobes)
        cfg_period = 3'd3;
        run(3, 1'b1);
        do_clear();
        cyc(1'b1);
        expect_st("R8 count cleared", 2'b00);
        run(2, 1'b1);
        expect_st("R8 still short", 2'b00);
        cyc(1'b1);
        expect_st("R8 fresh count", 2'b01);
        do_clear();

        // R4: interrupted run restarts (code 2 = 3 strobes)
        cfg_period = 3'd2;
        run(2, 1'b1);
        expect_st("R4 partial", 2'b00);
        wake_pin_in = 2'b00;
        run(3, 1'b0);
        wake_pin_in = 2'b01;
        run(2, 1'b0);
        cyc(1'b1);
        expect_st("R4 restart", 2'b00);
        run(2, 1'b1);
        expect_st("R4 full run", 2'b01);
        do_clear();

        // R6: disabled pin ignored
        cfg_period = 3'd1; cfg_pin_en = 2'b01; wake_pin_in = 2'b10;
        run(2, 1'b0);
        run(4, 1'b1);
        expect_st("R6 disabled", 2'b00);
        cfg_pin_en = 2'b11;
        run(2, 1'b1);
        expect_st("R6 enabled", 2'b10);
        do_clear();

        // R2: code 0 is off
        cfg_period = 3'd0; wake_pin_in = 2'b11;
        run(2, 1'b0);
        run(10, 1'b1);
        expect_st("R2 off", 2'b00);

        // R10: synchroniser latency
        cfg_period = 3'd1; wake_pin_in = 2'b00;
        run(3, 1'b0);
        wake_pin_in = 2'b11;
        run(2, 1'b1);
        expect_st("R10 early strobes", 2'b00);
        cyc(1'b1);
        expect_st("R10 first counted", 2'b00);
        cyc(1'b1);
        expect_st("R10 both set", 2'b11);
        do_clear();

        // R8: clear beats a simultaneous set
        cyc(1'b1);
        clear_cmd = 1'b1;
        cyc(1'b1);
        clear_cmd = 1'b0;
        expect_st("R8 clear wins", 2'b00);

        // R3: code 7 boundary = 8 strobes
        cfg_period = 3'd7; cfg_pin_en = 2'b01; wake_pin_in = 2'b01;
        do_clear();
        run(7, 1'b1);
        expect_st("R3 seven of eight", 2'b00);
        cyc(1'b1);
        expect_st("R3 eight of eight", 2'b01);

        // R1: reset clears flags
        rst_n = 1'b0;
        cyc(1'b0);
        expect_st("R1 reset again", 2'b00);
        rst_n = 1'b1;
        cyc(1'b0);

        finish_run();
    end

endmodule